// File: doc/BRIEF.md
# Two-Channel PWM Generator with Fractional Rate and Phase Nudge

This block produces two pulse-width-modulated outputs from one shared 16-bit counter. The counter does not run at the system clock rate. A fractional rate generator with an unsigned 8.4 fixed-point setting gates every count step. A larger setting gives a slower output. The counter has two modes. In sawtooth mode it wraps to zero. In phase-correct mode it climbs to the top value and then descends, which keeps each pulse centred in its period. The price is half the output frequency.

Each channel drives its pin high while its compare value is greater than the counter, and each channel has its own invert control. The compare values and the top value are applied at period boundaries, so a change never produces a short or split pulse. A one-cycle strobe marks each return of the counter to zero. Two request strobes shift the running phase by one count. An advance inserts one extra step into the gating. A retard removes one step from it. Each request stays pending, with its own busy flag, until it has been applied. All inputs are plain control levels and strobes, and all outputs are plain pins. There is no streamed data path, so the block has no valid/ready handshake and no back-pressure.

Top module: `pwm_slice`

## Requirements
- R1: The step gate uses `rate` as an 8.4 value: bits 11:4 are the integer part I and bits 3:0 are the fraction F. An integer part of 0 counts as 256. Each step interval lasts I cycles, plus one more cycle whenever adding F to a 4-bit fraction accumulator carried at the previous step. The average interval is therefore I + F/16 cycles. A rate of 1.0 (0x010) gives a step on every enabled cycle, and a rate of 0x000 behaves as 256.0.
- R2: In sawtooth mode (`centre_mode`=0) each step adds one to the counter. A step taken at or above the top value returns the counter to 0. The period is therefore (top+1) × rate system cycles.
- R3: In phase-correct mode (`centre_mode`=1) the counter counts up to top and then down to 0. It takes one step without moving at each end, so the sequence is 0,1,..,top,top,..,1,0. The period is 2 × (top+1) × rate cycles, and the high time is centred on the counter's zero.
- R4: While enabled, a channel's undriven level is high exactly when its applied compare value is greater than the counter. A compare of 0 keeps the level low for the whole period. A compare of top+1 keeps it high for the whole period.
- R5: `inv_a` and `inv_b` each invert only their own pin, and they take effect immediately.
- R6: While `run` is low, the counter, the rate generator and the wrap strobe are frozen. Both undriven levels are low, so each pin equals its invert bit. The compare and top values are taken directly from the inputs.
- R7: While `run` is high, new compare and top inputs are applied only at the step that returns the counter to 0. The period in progress finishes with the old values.
- R8: `wrap` is high for exactly one cycle after each step that returns the counter to 0, and in that cycle the counter is 0.
- R9: A one-cycle `adv_req` sets `adv_busy` in the next cycle. The request then inserts one extra step on the first enabled cycle that has no regular step, and `adv_busy` clears. The next period is shortened by one step interval.
- R10: A one-cycle `ret_req` sets `ret_busy` in the next cycle and removes the next regular step, which lengthens the period by one step interval. While `run` is low no regular step occurs, so the request stays pending and the counter never moves backward.
- R11: The counter never takes more than one step per cycle. At a rate of 1.0 an advance request therefore stays pending, with `adv_busy` high and the period unchanged, until a slower rate leaves a free cycle.
- R12: After reset the counter is 0, counting is upward, both busy flags and `wrap` are low, and with `run` low both pins equal their invert bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Counting enable |
| centre_mode | input | 1 | 1 selects phase-correct up/down counting |
| inv_a | input | 1 | Invert pin A |
| inv_b | input | 1 | Invert pin B |
| rate | input | 12 | Step rate, unsigned 8.4 fixed point |
| cmp_a | input | 16 | Compare value for channel A |
| cmp_b | input | 16 | Compare value for channel B |
| top | input | 16 | Highest counter value |
| adv_req | input | 1 | One-cycle phase advance request |
| ret_req | input | 1 | One-cycle phase retard request |
| pwm_a | output | 1 | PWM pin A |
| pwm_b | output | 1 | PWM pin B |
| wrap | output | 1 | One-cycle strobe when the counter returns to 0 |
| adv_busy | output | 1 | Advance request pending |
| ret_busy | output | 1 | Retard request pending |

## Verification
The case of interest is a pending phase advance that lands in the same cycle as a regular step of the rate generator. In that cycle a naive design would step twice. The bench provokes this by setting a rate of 1.0, where every cycle already carries a regular step, and raising an advance at a wrap. It then checks that the next wrap still comes exactly top+1 cycles later and that `adv_busy` stays high. After switching to rate 2.0 it checks that the request drains within a few cycles. A second collision, a retard raised while counting is disabled, is judged by `ret_busy` holding for tens of cycles with both pins constant, and then clearing once counting resumes.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned CNT_W      = 16;
  localparam int unsigned RATE_INT_W = 8;
  localparam int unsigned RATE_FRC_W = 4;
  localparam int unsigned NUM_CH     = 2;

  typedef enum logic {
    CNT_UP   = 1'b0,
    CNT_DOWN = 1'b1
  } cnt_dir_e;
endpackage

// File: rtl/pwm_rate_gen.sv
module pwm_rate_gen
  import pwm_pkg::*;
#(
  parameter int unsigned INT_W = RATE_INT_W,
  parameter int unsigned FRC_W = RATE_FRC_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [INT_W+FRC_W-1:0] rate,
  input  logic                   adv_req,
  input  logic                   ret_req,
  output logic                   step,
  output logic                   adv_busy,
  output logic                   ret_busy
);
  localparam int unsigned CYC_W     = INT_W + 2;
  localparam int unsigned INT_MAX_I = 1 << INT_W;
  localparam logic [CYC_W-1:0] INT_MAX = INT_MAX_I[CYC_W-1:0];
  localparam logic [CYC_W-1:0] ONE     = 1;

  logic [INT_W-1:0] int_part;
  logic [FRC_W-1:0] frc_part;
  logic [CYC_W-1:0] int_eff, target, cyc_q;
  logic [FRC_W-1:0] facc_q;
  logic [FRC_W:0]   facc_sum;
  logic             extra_q, natural, adv_q, ret_q;

  always_comb begin
    int_part = rate[INT_W+FRC_W-1:FRC_W];
    frc_part = rate[FRC_W-1:0];
    int_eff  = (int_part == '0) ? INT_MAX : {2'b00, int_part};
    target   = int_eff + (extra_q ? ONE : '0);
    natural  = en && ((cyc_q + ONE) >= target);
    facc_sum = {1'b0, facc_q} + {1'b0, frc_part};
    step     = natural ? !ret_q : (en && adv_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      facc_q  <= '0;
      extra_q <= 1'b0;
      adv_q   <= 1'b0;
      ret_q   <= 1'b0;
    end else begin
      if (en) begin
        if (natural) begin
          cyc_q   <= '0;
          facc_q  <= facc_sum[FRC_W-1:0];
          extra_q <= facc_sum[FRC_W];
        end else begin
          cyc_q <= cyc_q + ONE;
        end
      end
      adv_q <= adv_req || (adv_q && !(en && !natural));
      ret_q <= ret_req || (ret_q && !natural);
    end
  end

  assign adv_busy = adv_q;
  assign ret_busy = ret_q;

  // R9
  adv_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_req |=> adv_busy);
  // R9
  adv_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_q && en && !natural && !adv_req) |=> !adv_busy);
  // R10
  ret_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_q && natural && !ret_req) |=> !ret_busy);
  // R10
  ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_q && !en) |=> ret_busy);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
#(
  parameter int unsigned W   = CNT_W,
  parameter int unsigned NCH = NUM_CH
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    step,
  input  logic                    centre,
  input  logic [W-1:0]            top_in,
  input  logic [NCH-1:0][W-1:0]   cmp_in,
  output logic [W-1:0]            cnt,
  output logic [NCH-1:0][W-1:0]   cmp_act,
  output logic                    wrap
);
  localparam logic [W-1:0] ONE = 1;

  logic [W-1:0]          cnt_q, top_q;
  logic [NCH-1:0][W-1:0] cmp_q;
  cnt_dir_e              dir_q;
  logic                  wrap_q, at_top, at_zero, to_zero;

  always_comb begin
    at_top  = cnt_q >= top_q;
    at_zero = cnt_q == '0;
    to_zero = step && (centre ? (dir_q == CNT_DOWN && at_zero) : at_top);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      top_q  <= '0;
      cmp_q  <= '0;
      dir_q  <= CNT_UP;
      wrap_q <= 1'b0;
    end else if (!en) begin
      top_q  <= top_in;
      cmp_q  <= cmp_in;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= to_zero;
      if (to_zero) begin
        top_q <= top_in;
        cmp_q <= cmp_in;
      end
      if (step) begin
        if (!centre) begin
          dir_q <= CNT_UP;
          cnt_q <= at_top ? '0 : cnt_q + ONE;
        end else if (dir_q == CNT_UP) begin
          if (at_top) dir_q <= CNT_DOWN;
          else        cnt_q <= cnt_q + ONE;
        end else begin
          if (at_zero) dir_q <= CNT_UP;
          else         cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  assign cnt     = cnt_q;
  assign cmp_act = cmp_q;
  assign wrap    = wrap_q;

  // R6
  frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q));
  // R8
  wrap_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |-> (cnt_q == '0));
  // R3
  descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step && centre && dir_q == CNT_DOWN && !at_zero) |=> (cnt_q < $past(cnt_q)));
  // R7
  hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !to_zero) |=> $stable(top_q));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         en,
  input  logic         inv,
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] cnt,
  output logic         pin
);
  logic level;

  always_comb begin
    level = en && (cmp > cnt);
    pin   = level ^ inv;
  end
endmodule

// File: rtl/pwm_slice.sv
module pwm_slice
  import pwm_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         run,
  input  logic                         centre_mode,
  input  logic                         inv_a,
  input  logic                         inv_b,
  input  logic [RATE_INT_W+RATE_FRC_W-1:0] rate,
  input  logic [CNT_W-1:0]             cmp_a,
  input  logic [CNT_W-1:0]             cmp_b,
  input  logic [CNT_W-1:0]             top,
  input  logic                         adv_req,
  input  logic                         ret_req,
  output logic                         pwm_a,
  output logic                         pwm_b,
  output logic                         wrap,
  output logic                         adv_busy,
  output logic                         ret_busy
);
  logic                        step;
  logic [CNT_W-1:0]            cnt;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_in, cmp_act;
  logic [NUM_CH-1:0]           inv_vec, pin_vec;

  assign cmp_in  = {cmp_b, cmp_a};
  assign inv_vec = {inv_b, inv_a};

  pwm_rate_gen #(.INT_W(RATE_INT_W), .FRC_W(RATE_FRC_W)) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (run),
    .rate     (rate),
    .adv_req  (adv_req),
    .ret_req  (ret_req),
    .step     (step),
    .adv_busy (adv_busy),
    .ret_busy (ret_busy)
  );

  pwm_counter #(.W(CNT_W), .NCH(NUM_CH)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (run),
    .step    (step),
    .centre  (centre_mode),
    .top_in  (top),
    .cmp_in  (cmp_in),
    .cnt     (cnt),
    .cmp_act (cmp_act),
    .wrap    (wrap)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    pwm_chan #(.W(CNT_W)) u_chan (
      .en  (run),
      .inv (inv_vec[ch]),
      .cmp (cmp_act[ch]),
      .cnt (cnt),
      .pin (pin_vec[ch])
    );
  end

  assign pwm_a = pin_vec[0];
  assign pwm_b = pin_vec[1];

  // R4
  pin_a_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && run) |-> (pwm_a == ((cmp_act[0] != '0) ^ inv_a)));
  // R4
  pin_b_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && run) |-> (pwm_b == ((cmp_act[1] != '0) ^ inv_b)));
  // R6
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pwm_a == inv_a && pwm_b == inv_b && !wrap));
endmodule

// File: tb/pwm_slice_tb.sv
module pwm_slice_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0, centre_mode = 1'b0, inv_a = 1'b0, inv_b = 1'b0;
  logic [11:0] rate = 12'h010;
  logic [15:0] cmp_a = 16'd3, cmp_b = 16'd7, top = 16'd9;
  logic        adv_req = 1'b0, ret_req = 1'b0;
  logic        pwm_a, pwm_b, wrap, adv_busy, ret_busy;
  int          errors = 0;
  int          checks = 0;

  always #10 clk = ~clk;

  pwm_slice dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .centre_mode(centre_mode),
    .inv_a(inv_a), .inv_b(inv_b), .rate(rate), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .top(top), .adv_req(adv_req), .ret_req(ret_req), .pwm_a(pwm_a),
    .pwm_b(pwm_b), .wrap(wrap), .adv_busy(adv_busy), .ret_busy(ret_busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_wrap();
    int n = 0;
    @(negedge clk);
    while (!wrap && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 3000) chk("R8 wrap timeout", 0, 1);
  endtask

  task automatic settle();
    next_wrap();
    next_wrap();
  endtask

  // Called at a wrap sample; measures cycles to the next wrap and high samples.
  task automatic measure(input bit adv, input bit ret,
                         output int len, output int ha, output int hb, output int busy1);
    len = 0; ha = 0; hb = 0; busy1 = 0;
    adv_req = adv;
    ret_req = ret;
    do begin
      ha += int'(pwm_a);
      hb += int'(pwm_b);
      len++;
      @(negedge clk);
      if (len == 1) begin
        adv_req = 1'b0;
        ret_req = 1'b0;
        busy1 = adv ? int'(adv_busy) : int'(ret_busy);
      end
    end while (!wrap && len < 3000);
  endtask

  task automatic t_reset();
    chk("R12 pwm_a", int'(pwm_a), 0);
    chk("R12 pwm_b", int'(pwm_b), 0);
    chk("R12 wrap", int'(wrap), 0);
    chk("R12 busy", int'(adv_busy) + int'(ret_busy), 0);
  endtask

  task automatic t_sawtooth();
    int len, ha, hb, b;
    run = 1; rate = 12'h010; top = 9; cmp_a = 3; cmp_b = 7;
    settle();
    measure(0, 0, len, ha, hb, b);
    chk("R2 period", len, 10);
    chk("R4 high A", ha, 3);
    chk("R4 high B", hb, 7);
    cmp_a = 0; cmp_b = 10;
    settle();
    measure(0, 0, len, ha, hb, b);
    chk("R4 compare 0 low", ha, 0);
    chk("R4 compare top+1 high", hb, 10);
    cmp_a = 3; cmp_b = 7; inv_a = 1;
    settle();
    measure(0, 0, len, ha, hb, b);
    chk("R5 inverted A", ha, 7);
    chk("R5 B untouched", hb, 7);
    inv_a = 0;
  endtask

  task automatic t_rate();
    int len, ha, hb, b;
    rate = 12'h020;
    settle();
    measure(0, 0, len, ha, hb, b);
    chk("R1 rate 2.0 period", len, 20);
    chk("R1 rate 2.0 high A", ha, 6);
    rate = 12'h018;
    settle();
    measure(0, 0, len, ha, hb, b);
    chk("R1 rate 1.5 period", len, 15);
    rate = 12'h000; top = 1; cmp_a = 1;
    settle();
    measure(0, 0, len, ha, hb, b);
    chk("R1 rate 0 as 256 period", len, 512);
    chk("R1 rate 0 high A", ha, 256);
    rate = 12'h010; top = 9; cmp_a = 3;
  endtask

  task automatic t_centre();
    int len, ha, hb, b;
    centre_mode = 1; top = 4; cmp_a = 2; cmp_b = 5;
    settle();
    measure(0, 0, len, ha, hb, b);
    chk("R3 period", len, 10);
    chk("R3 centred high A", ha, 4);
    chk("R3 top+1 high B", hb, 10);
    rate = 12'h020;
    settle();
    measure(0, 0, len, ha, hb, b);
    chk("R3 period at rate 2.0", len, 20);
    centre_mode = 0; rate = 12'h010; top = 9; cmp_a = 3; cmp_b = 7;
    settle();
  endtask

  task automatic t_buffer();
    int len, ha, n;
    next_wrap();
    len = 0; ha = 0;
    do begin
      ha += int'(pwm_a);
      len++;
      @(negedge clk);
      if (len == 1) chk("R8 single-cycle wrap", int'(wrap), 0);
      if (len == 2) begin cmp_a = 8; top = 5; end
    end while (!wrap && len < 3000);
    chk("R7 old top kept", len, 10);
    chk("R7 old compare kept", ha, 3);
    len = 0; ha = 0; n = 0;
    do begin
      ha += int'(pwm_a);
      len++;
      @(negedge clk);
    end while (!wrap && len < 3000);
    chk("R7 new top applied", len, 6);
    chk("R7 new compare applied", ha, 6);
    cmp_a = 3; top = 9;
    settle();
  endtask

  task automatic t_phase();
    int len, ha, hb, b;
    rate = 12'h040;
    settle();
    measure(1, 0, len, ha, hb, b);
    chk("R9 adv busy set", b, 1);
    chk("R9 advanced period", len, 36);
    chk("R9 adv busy cleared", int'(adv_busy), 0);
    measure(0, 1, len, ha, hb, b);
    chk("R10 ret busy set", b, 1);
    chk("R10 retarded period", len, 44);
    chk("R10 ret busy cleared", int'(ret_busy), 0);
  endtask

  task automatic t_adv_full_rate();
    int len, ha, hb, b;
    rate = 12'h010;
    settle();
    measure(1, 0, len, ha, hb, b);
    chk("R11 period unchanged at rate 1.0", len, 10);
    chk("R11 adv still pending", int'(adv_busy), 1);
    rate = 12'h020;
    repeat (6) @(negedge clk);
    chk("R11 adv drained at rate 2.0", int'(adv_busy), 0);
    rate = 12'h010;
  endtask

  task automatic t_disable();
    int ones_a = 0, ones_b = 0, wraps = 0;
    run = 0; inv_a = 1; inv_b = 0;
    @(negedge clk);
    ret_req = 1;
    @(negedge clk);
    ret_req = 0;
    for (int i = 0; i < 40; i++) begin
      ones_a += int'(pwm_a);
      ones_b += int'(pwm_b);
      wraps  += int'(wrap);
      @(negedge clk);
    end
    chk("R6 pin A equals invert", ones_a, 40);
    chk("R6 pin B equals invert", ones_b, 0);
    chk("R6 no wrap while off", wraps, 0);
    chk("R10 retard pending while off", int'(ret_busy), 1);
    inv_a = 0; run = 1;
    repeat (5) @(negedge clk);
    chk("R10 retard applied after enable", int'(ret_busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_sawtooth();
    t_rate();
    t_centre();
    t_buffer();
    t_phase();
    t_adv_full_rate();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule